// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block is a small instruction cache that sits between a 32-bit processor's fetch stage and its memory port. The fetch stage asks for one 16-bit instruction word at a time, giving a byte address and a flag that says whether it runs in supervisor mode. A lookup that hits returns the word on the next cycle. A lookup that misses loads one aligned 32-bit long word from memory into its line and then returns the requested half. The cache has 64 lines. Bits [7:2] of the address pick the line. The stored tag holds the upper address bits and also the mode flag, so code fetched in user mode and code fetched in supervisor mode never share a line.

A five-bit control register sets the cache's behaviour. One bit switches the cache on. One bit freezes its contents, so lookups can still hit but misses no longer fill. Two write-only strobes drop either one line or every line. A burst-enable bit can be stored and read back. The line that the single-line clear acts on comes from a separate line-select register.

The memory port can answer with a bus error. If a line fill ends in a bus error, the line is left as it was and the word is then read directly from memory. If a direct word read ends in a bus error, that error is passed on with the response.

Top module: `insn_cache`

## Requirements
- R1: A lookup hits when the cache is enabled, the selected line is valid and its stored tag equals the request tag. A hit sets rsp_valid one cycle after the request is accepted, returns the word and makes no memory request.
- R2: The line is selected by address bits [7:2], which gives 64 lines. A fill to a line replaces whatever that line held before, so an address with a different tag at the same index misses afterwards.
- R3: The tag is address bits [31:8] with req_super added as an extra most-significant bit. A user fetch and a supervisor fetch to the same address never hit each other's line.
- R4: With the cache enabled and not frozen, a miss sends one long-word read (mem_req_long=1) to the request address with bits [1:0] forced to 0. When that read completes without error, the line is stored with its tag and marked valid, and the word is returned.
- R5: When address bit 1 is 0, the returned word is bits [31:16] of the long word. When address bit 1 is 1, it is bits [15:0].
- R6: While the enable bit (control bit 0) is clear, every fetch makes one direct word read (mem_req_long=0, full address) and returns mem_rsp_data[15:0]. Stored lines are kept, and they hit again once the cache is re-enabled.
- R7: While the freeze bit (control bit 1) is set, hits are still served. A miss makes a direct word read and leaves the line unchanged, so fetching the same address again misses again.
- R8: A fill that ends with mem_rsp_err=1 does not change the tag, the data or the valid bit of its line. A direct word read follows, and rsp_err reports that read's error flag together with its word.
- R9: Writing the control register with bit 3 set invalidates every line and sets every stored tag to all ones, in the same clock edge. A fill that completes on that same edge is also dropped.
- R10: Writing the control register with bit 2 set invalidates only the line whose index is held in the line-select register. Every other line keeps its contents.
- R11: ctl_rdata shows the stored enable (bit 0), freeze (bit 1) and burst (bit 4) values. Bits 2 and 3 always read 0. The burst bit has no effect on how lines are filled.
- R12: req_ready is low from the acceptance of a miss until its response. Each accepted request produces exactly one single-cycle rsp_valid. A memory request is held stable until its response arrives.
- R13: After reset the control register reads 0 (cache disabled), all lines are invalid, req_ready is 1, and rsp_valid and mem_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the instruction word |
| req_super | input | 1 | Request made in supervisor mode |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_word | output | 16 | Returned instruction word |
| rsp_err | output | 1 | Direct word read ended in a bus error |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data: 0 enable, 1 freeze, 2 clear line, 3 clear all, 4 burst |
| ctl_rdata | output | 5 | Control register read value |
| cline_we | input | 1 | Line-select register write strobe |
| cline_wdata | input | log2(LINES) | Line index (address bits [7:2]) for the single-line clear |
| mem_req_valid | output | 1 | Memory read request, held until its response |
| mem_req_long | output | 1 | 1: long-word line fill, 0: direct word read |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | 32 | Long word, or the word in bits [15:0] |
| mem_rsp_err | input | 1 | Bus error on this response |

## Verification
The assertions assume that the memory side raises mem_rsp_valid only while a request is outstanding, and only for one cycle per request. Under that assumption, a held request and a direct read that follows a failed fill are properties of the cache itself. The assertions also assume that requests are only presented with a meaningful address. The bench memory keeps to these rules: it counts a fixed latency from the moment it sees mem_req_valid, gives exactly one response pulse, and injects a bus error only on the chosen long-word or word addresses. The bench always waits for a response before it issues the next fetch.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int LONG_W = 32;
    localparam int WORD_W = 16;
    localparam int CTL_W  = 5;

    // control register bit positions (software-visible encoding)
    localparam int CTL_EN      = 0;
    localparam int CTL_FRZ     = 1;
    localparam int CTL_CLR_ONE = 2;
    localparam int CTL_CLR_ALL = 3;
    localparam int CTL_BURST   = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FILL   = 2'd1,
        SEQ_DIRECT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic burst;
        logic freeze;
        logic enable;
    } ctl_state_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic              err;
    } rsp_t;

    // upper half for an even word, lower half for an odd word
    function automatic logic [WORD_W-1:0] pick_half(input logic [LONG_W-1:0] lw,
                                                    input logic              odd);
        return odd ? lw[WORD_W-1:0] : lw[LONG_W-1:WORD_W];
    endfunction

endpackage

// File: rtl/icache_ctl.sv
module icache_ctl
    import icache_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             line_we,
    input  logic [IDX_W-1:0] line_wdata,
    output ctl_state_t       st,
    output logic             clr_all,
    output logic             clr_one,
    output logic [IDX_W-1:0] clr_idx,
    output logic [CTL_W-1:0] rdata
);

    ctl_state_t       st_q;
    logic [IDX_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            line_q <= '0;
        end else begin
            if (we) begin
                st_q.enable <= wdata[CTL_EN];
                st_q.freeze <= wdata[CTL_FRZ];
                st_q.burst  <= wdata[CTL_BURST];
            end
            if (line_we) begin
                line_q <= line_wdata;
            end
        end
    end

    // clear strobes act on the write edge itself and are never held
    assign clr_all = we && wdata[CTL_CLR_ALL];
    assign clr_one = we && wdata[CTL_CLR_ONE];
    assign clr_idx = line_q;
    assign st      = st_q;

    always_comb begin
        rdata            = '0;
        rdata[CTL_EN]    = st_q.enable;
        rdata[CTL_FRZ]   = st_q.freeze;
        rdata[CTL_BURST] = st_q.burst;
    end

endmodule

// File: rtl/icache_lines.sv
module icache_lines
    import icache_pkg::*;
#(
    parameter int LINES = 64,
    parameter int TAG_W = 25,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LONG_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LONG_W-1:0] wr_data,
    input  logic              clr_all,
    input  logic              clr_one,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic [LINES-1:0]  valid_vec
);

    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [LONG_W-1:0] data_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [LONG_W-1:0] d_q;
        logic              hit_clr;
        logic              hit_wr;

        assign hit_clr = clr_all || (clr_one && (clr_idx == IDX_W'(g)));
        assign hit_wr  = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                t_q <= '1;
                d_q <= '0;
            end else if (hit_clr) begin
                v_q <= 1'b0;
                t_q <= '1;
            end else if (hit_wr) begin
                v_q <= 1'b1;
                t_q <= wr_tag;
                d_q <= wr_data;
            end
        end

        assign valid_vec[g] = v_q;
        assign tag_arr[g]   = t_q;
        assign data_arr[g]  = d_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];
    assign rd_data  = data_arr[rd_idx];

endmodule

// File: rtl/icache_seq.sv
module icache_seq
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    localparam int TAG_W = ADDR_W - IDX_W - 2 + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              freeze,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_super,
    output rsp_t              rsp,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [LONG_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [LONG_W-1:0] wr_data,
    output logic              mem_req_valid,
    output logic              mem_req_long,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LONG_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err
);

    localparam int IDX_LO = 2;
    localparam int TAG_LO = IDX_LO + IDX_W;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              super_q;
    rsp_t              rsp_q;

    logic             accept;
    logic [TAG_W-1:0] req_tag;
    logic             hit;

    assign req_ready = (state_q == SEQ_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_idx    = req_addr[TAG_LO-1:IDX_LO];
    assign req_tag   = {req_super, req_addr[ADDR_W-1:TAG_LO]};
    assign hit       = enable && rd_valid && (rd_tag == req_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            super_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            rsp_q.valid <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        addr_q  <= req_addr;
                        super_q <= req_super;
                        if (hit) begin
                            rsp_q.valid <= 1'b1;
                            rsp_q.word  <= pick_half(rd_data, req_addr[1]);
                            rsp_q.err   <= 1'b0;
                        end else if (enable && !freeze) begin
                            state_q <= SEQ_FILL;
                        end else begin
                            state_q <= SEQ_DIRECT;
                        end
                    end
                end
                SEQ_FILL: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            state_q <= SEQ_DIRECT;
                        end else begin
                            state_q     <= SEQ_IDLE;
                            rsp_q.valid <= 1'b1;
                            rsp_q.word  <= pick_half(mem_rsp_data, addr_q[1]);
                            rsp_q.err   <= 1'b0;
                        end
                    end
                end
                SEQ_DIRECT: begin
                    if (mem_rsp_valid) begin
                        state_q     <= SEQ_IDLE;
                        rsp_q.valid <= 1'b1;
                        rsp_q.word  <= mem_rsp_data[WORD_W-1:0];
                        rsp_q.err   <= mem_rsp_err;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign rsp           = rsp_q;
    assign mem_req_valid = (state_q == SEQ_FILL) || (state_q == SEQ_DIRECT);
    assign mem_req_long  = (state_q == SEQ_FILL);
    assign mem_req_addr  = mem_req_long ? {addr_q[ADDR_W-1:IDX_LO], 2'b00} : addr_q;

    assign wr_en   = (state_q == SEQ_FILL) && mem_rsp_valid && !mem_rsp_err;
    assign wr_idx  = addr_q[TAG_LO-1:IDX_LO];
    assign wr_tag  = {super_q, addr_q[ADDR_W-1:TAG_LO]};
    assign wr_data = mem_rsp_data;

endmodule

// File: rtl/insn_cache.sv
module insn_cache
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 64,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W - 2 + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_super,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic              rsp_err,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              cline_we,
    input  logic [IDX_W-1:0]  cline_wdata,
    output logic              mem_req_valid,
    output logic              mem_req_long,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LONG_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err
);

    ctl_state_t        ctl_st;
    logic              clr_all;
    logic              clr_one;
    logic [IDX_W-1:0]  clr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [LONG_W-1:0] rd_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [LONG_W-1:0] wr_data;
    logic [LINES-1:0]  line_valid;
    rsp_t              rsp;

    icache_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .wdata      (ctl_wdata),
        .line_we    (cline_we),
        .line_wdata (cline_wdata),
        .st         (ctl_st),
        .clr_all    (clr_all),
        .clr_one    (clr_one),
        .clr_idx    (clr_idx),
        .rdata      (ctl_rdata)
    );

    icache_lines #(.LINES(LINES), .TAG_W(TAG_W)) u_lines (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data),
        .clr_all   (clr_all),
        .clr_one   (clr_one),
        .clr_idx   (clr_idx),
        .valid_vec (line_valid)
    );

    icache_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .enable        (ctl_st.enable),
        .freeze        (ctl_st.freeze),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_super     (req_super),
        .rsp           (rsp),
        .rd_idx        (rd_idx),
        .rd_valid      (rd_valid),
        .rd_tag        (rd_tag),
        .rd_data       (rd_data),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_tag        (wr_tag),
        .wr_data       (wr_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_long  (mem_req_long),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_word  = rsp.word;
    assign rsp_err   = rsp.err;

endmodule

// File: rtl/insn_cache_chk.sv
module insn_cache_chk
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              ctl_we,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic              mem_req_valid,
    input logic              mem_req_long,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_err,
    input logic [LINES-1:0]  line_valid
);

    assert_rsp_only_when_ready_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    assert_mem_busy_blocks_req_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    assert_mem_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_long)));

    assert_fill_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_long) |-> (mem_req_addr[1:0] == 2'b00));

    assert_fill_err_goes_direct_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_long && mem_rsp_valid && mem_rsp_err) |=>
            (mem_req_valid && !mem_req_long));

    assert_disabled_goes_direct_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctl_rdata[CTL_EN] && req_valid && req_ready) |=> (mem_req_valid && !mem_req_long));

    assert_clear_all_empties_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[CTL_CLR_ALL]) |=> (line_valid == '0));

    assert_clear_bits_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[CTL_CLR_ALL:CTL_CLR_ONE] == 2'b00);

endmodule

bind insn_cache insn_cache_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .ctl_we        (ctl_we),
    .ctl_wdata     (ctl_wdata),
    .ctl_rdata     (ctl_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_long  (mem_req_long),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .line_valid    (line_valid)
);

// File: tb/insn_cache_tb.sv
module insn_cache_tb;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_super = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_word;
    logic        rsp_err;
    logic        ctl_we = 1'b0;
    logic [4:0]  ctl_wdata = '0;
    logic [4:0]  ctl_rdata;
    logic        cline_we = 1'b0;
    logic [5:0]  cline_wdata = '0;
    logic        mem_req_valid;
    logic        mem_req_long;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    always #5 clk = ~clk;

    insn_cache u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_super(req_super),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_err(rsp_err),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .cline_we(cline_we), .cline_wdata(cline_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_long(mem_req_long), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int n_long = 0;
    int n_word = 0;
    int cnt    = 0;
    int cyc    = 0;
    bit pending = 1'b0;
    logic [31:0] bad_long = 32'hFFFF_FFFF;
    logic [31:0] bad_word = 32'hFFFF_FFFF;

    // behavioural reference state
    bit          m_val [64];
    logic [24:0] m_tag [64];
    logic [31:0] m_dat [64];
    bit          m_en = 1'b0;
    bit          m_frz = 1'b0;
    int          m_line = 0;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'hA5A5_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: answers after LAT cycles, one pulse per request
    always @(negedge clk) begin
        logic [31:0] v;
        if (rst) begin
            mem_rsp_valid = 1'b0;
            cnt = 0;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err = 1'b0;
            cnt = 0;
        end else if (mem_req_valid) begin
            if (cnt == LAT) begin
                mem_rsp_valid = 1'b1;
                if (mem_req_long) begin
                    n_long++;
                    mem_rsp_data = memval(mem_req_addr);
                    mem_rsp_err = (mem_req_addr == bad_long);
                end else begin
                    n_word++;
                    v = memval({mem_req_addr[31:2], 2'b00});
                    mem_rsp_data = {16'h0, mem_req_addr[1] ? v[15:0] : v[31:16]};
                    mem_rsp_err = ({mem_req_addr[31:2], 2'b00} == bad_word);
                end
            end else begin
                cnt++;
            end
        end
    end

    // per-clock monitor: no response without an outstanding fetch (R12)
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            chk(pending, "R12 unexpected rsp_valid", {31'h0, rsp_valid}, 32'h0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wr_ctl(input logic [4:0] d);
        m_en  = d[0];
        m_frz = d[1];
        if (d[3]) begin
            for (int i = 0; i < 64; i++) m_val[i] = 1'b0;
        end
        if (d[2]) m_val[m_line] = 1'b0;
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_wdata = '0;
    endtask

    task automatic wr_line(input int idx);
        m_line = idx;
        @(negedge clk);
        cline_we = 1'b1;
        cline_wdata = 6'(idx);
        @(negedge clk);
        cline_we = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] a, input bit s, input string req);
        int          idx;
        logic [24:0] t;
        bit          e_hit, e_fill, f_err, e_dir, e_err, rdy_bad;
        logic [31:0] lv;
        logic [15:0] e_word;
        int          l0, w0, cycles;
        idx    = int'(a[7:2]);
        t      = {s, a[31:8]};
        e_hit  = m_en && m_val[idx] && (m_tag[idx] == t);
        e_fill = !e_hit && m_en && !m_frz;
        f_err  = e_fill && ({a[31:2], 2'b00} == bad_long);
        e_dir  = !e_hit && (!e_fill || f_err);
        e_err  = e_dir && ({a[31:2], 2'b00} == bad_word);
        lv     = e_hit ? m_dat[idx] : memval({a[31:2], 2'b00});
        e_word = a[1] ? lv[15:0] : lv[31:16];
        if (e_fill && !f_err) begin
            m_val[idx] = 1'b1;
            m_tag[idx] = t;
            m_dat[idx] = lv;
        end
        l0 = n_long;
        w0 = n_word;
        rdy_bad = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_super = s;
        pending   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cycles = 1;
        while (!rsp_valid && cycles < 60) begin
            if (req_ready) rdy_bad = 1'b1;
            @(negedge clk);
            cycles++;
        end
        chk(rsp_valid, {req, " response"}, {31'h0, rsp_valid}, 32'h1);
        chk(rsp_word == e_word, {req, " word"}, {16'h0, rsp_word}, {16'h0, e_word});
        chk(rsp_err == e_err, {req, " R8 rsp_err"}, {31'h0, rsp_err}, {31'h0, e_err});
        chk((n_long - l0) == (e_fill ? 1 : 0), {req, " R4 long reads"}, n_long - l0, e_fill ? 1 : 0);
        chk((n_word - w0) == (e_dir ? 1 : 0), {req, " R6 word reads"}, n_word - w0, e_dir ? 1 : 0);
        if (e_hit) chk(cycles == 1, {req, " R1 hit latency"}, cycles, 1);
        else       chk(!rdy_bad, {req, " R12 ready during miss"}, {31'h0, rdy_bad}, 32'h0);
        #1 pending = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_val[i] = 1'b0;
            m_tag[i] = '1;
            m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        chk(req_ready == 1'b1, "R13 req_ready", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R13 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk(mem_req_valid == 1'b0, "R13 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        chk(ctl_rdata == 5'b0, "R13 ctl_rdata", {27'h0, ctl_rdata}, 32'h0);

        fetch(32'h0000_1000, 1'b0, "R6 disabled");
        wr_ctl(5'b00001);
        fetch(32'h0000_1000, 1'b0, "R4 fill");
        fetch(32'h0000_1002, 1'b0, "R5 odd half hit");
        fetch(32'h0000_1000, 1'b0, "R5 even half hit");
        fetch(32'h0000_1000, 1'b1, "R3 super misses user line");
        fetch(32'h0000_1000, 1'b1, "R3 super hit");
        fetch(32'h0000_1002, 1'b0, "R3 user misses super line");
        fetch(32'h0000_1004, 1'b0, "R2 fill idx1");
        fetch(32'h0000_1104, 1'b0, "R2 alias replaces");
        fetch(32'h0000_1006, 1'b0, "R2 old tag misses");

        wr_ctl(5'b00000);
        fetch(32'h0000_1006, 1'b0, "R6 disabled bypass");
        wr_ctl(5'b00001);
        fetch(32'h0000_1004, 1'b0, "R6 contents kept");

        wr_ctl(5'b00011);
        fetch(32'h0000_1006, 1'b0, "R7 frozen hit");
        fetch(32'h0000_3008, 1'b0, "R7 frozen miss");
        fetch(32'h0000_300A, 1'b0, "R7 still not filled");
        wr_ctl(5'b00001);

        bad_long = 32'h0000_4010;
        fetch(32'h0000_4012, 1'b0, "R8 fill error");
        fetch(32'h0000_4010, 1'b0, "R8 line not validated");
        bad_word = 32'h0000_4010;
        fetch(32'h0000_4012, 1'b1, "R8 direct error");
        bad_long = 32'hFFFF_FFFF;
        bad_word = 32'hFFFF_FFFF;

        fetch(32'h0000_5020, 1'b0, "R10 fill idx8");
        fetch(32'h0000_5024, 1'b0, "R10 fill idx9");
        wr_line(8);
        wr_ctl(5'b00101);
        chk(ctl_rdata == 5'b00001, "R11 clear bits not stored", {27'h0, ctl_rdata}, 32'h1);
        fetch(32'h0000_5026, 1'b0, "R10 other line kept");
        fetch(32'h0000_5022, 1'b0, "R10 selected line dropped");

        wr_ctl(5'b01001);
        fetch(32'h0000_5024, 1'b0, "R9 clear all");
        fetch(32'h0000_5022, 1'b0, "R9 clear all second line");

        wr_ctl(5'b10011);
        chk(ctl_rdata == 5'b10011, "R11 readback", {27'h0, ctl_rdata}, 32'h13);
        wr_ctl(5'b10001);
        chk(ctl_rdata == 5'b10001, "R11 readback burst", {27'h0, ctl_rdata}, 32'h11);
        fetch(32'h0000_7040, 1'b0, "R11 burst single long fill");
        fetch(32'h0000_7042, 1'b0, "R11 burst hit");

        for (int i = 0; i < 64; i++) fetch(32'h0006_0000 + 32'(i * 4), 1'b0, "R2 sweep fill");
        for (int i = 0; i < 64; i += 7) fetch(32'h0006_0002 + 32'(i * 4), 1'b0, "R2 sweep hit");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule